// File: doc/BRIEF.md
# Seconds-Counting Real-Time Clock with Alarm

This block keeps wall-clock time as a single unsigned count of seconds. A free-running counter advances by one on every cycle in which the once-per-second tick input is high, but only while software has switched counting on. Software can preset the count at any moment. It can also program an alarm value. When the counter reaches the alarm value, an interrupt is raised.

Software reaches the block through a plain register port: a valid strobe, a write flag, a byte address and 32-bit write data. Read data is combinational. It is valid in the same cycle as a read access and zero at all other times. The alarm condition is latched in a raw status bit. A mask bit gates that raw bit onto the interrupt output. Software reads the raw bit and the gated bit at separate offsets, and acknowledges the alarm by writing a one at a third offset.

Top module: `sec_rtc`

## Requirements
- R1: After a synchronous active-low reset, these are all zero: the counter, the alarm value, the enable bit, the mask bit, the raw status and the interrupt output. Every register read returns zero.
- R2: A read at byte offset 0x00 returns the counter value. A write at offset 0x08 presets the counter to the written value at the next clock edge. This preset takes priority over a tick in the same cycle.
- R3: Bit 0 of the control register (offset 0x0C, read back in bit 0) enables counting. The counter steps by exactly one on a cycle where the tick input is high and the enable bit is already set. The counter holds when the tick is low or the enable bit is clear.
- R4: Counting past 0xFFFFFFFF gives 0. That wrapped value can trigger the alarm like any other value.
- R5: The 32-bit alarm value is written and read back at offset 0x04.
- R6: The raw status bit (offset 0x14, bit 0) sets at the clock edge where the counter takes a new value, by a tick or by a preset, that equals the alarm value held before that edge. Writing an alarm value equal to the present count does not set it. Once set, the bit stays set until it is acknowledged.
- R7: The mask bit is read and written at offset 0x10, bit 0. The masked status at offset 0x18, bit 0, equals raw status AND mask. The interrupt output always equals the masked status.
- R8: Writing a word with bit 0 set to offset 0x1C clears the raw status. Writing bit 0 as zero there has no effect. A new alarm hit at the same edge as the clear leaves the raw status set.
- R9: For reads, these all return zero: upper bits of the single-bit registers, offsets 0x08 and 0x1C, misaligned addresses and offsets at or above 0x20. Writes to misaligned or out-of-range addresses, and to offsets 0x00, 0x14 and 0x18, change nothing.
- R10: The read data output is zero in any cycle without a read access (valid low, or a write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Once-per-second tick enable |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid during a read access |
| irq_o | output | 1 | Alarm interrupt (raw status AND mask) |

## Verification
The bench checks these corner cases:

- A clear arriving in the same cycle as a new alarm hit. A design where the clear wins would drop an alarm silently.
- A preset in the same cycle as a tick. The counter must land on the written value, not that value plus one.
- Writing an alarm value equal to the running count. A design that compares levels instead of updates would fire spuriously, and after reset it would fire at once because both values are zero.
- The wrap from all-ones to zero, and reaching the alarm through a preset rather than a tick.
- Writes to misaligned, out-of-range and read-only offsets, with the bench confirming that no visible register moved. An address decoder that ignores the low or high address bits would let these writes alias onto real registers.

// File: rtl/sec_rtc_pkg.sv
// Shared types for the seconds RTC.
// Assumes word-aligned byte addressing with eight 32-bit slots starting at zero.
package sec_rtc_pkg;

    // Word slot numbers (byte offset / 4); the order fixes the register map.
    typedef enum logic [2:0] {
        SLOT_COUNT  = 3'd0,
        SLOT_ALARM  = 3'd1,
        SLOT_PRESET = 3'd2,
        SLOT_CTRL   = 3'd3,
        SLOT_MASK   = 3'd4,
        SLOT_RAW    = 3'd5,
        SLOT_MASKED = 3'd6,
        SLOT_ACK    = 3'd7
    } slot_e;

    // One write strobe per writable register.
    typedef struct packed {
        logic alarm;
        logic preset;
        logic ctrl;
        logic mask;
        logic ack;
    } wr_strobe_t;

endpackage

// File: rtl/sec_rtc_counter.sv
// Seconds counter with preset and enable.
// Does: holds the enable bit and the count; a preset beats a tick in the same cycle.
// Assumes: tick_i is a single-cycle strobe once per second, synchronous to clk.
module sec_rtc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_wr_i,
    input  logic             en_val_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             en_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             upd_o,
    output logic [CNT_W-1:0] nxt_o
);

    logic             en_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             cnt_upd;

    // Purpose: pick the next count and flag whether the count is being updated.
    always_comb begin
        cnt_nxt = cnt_q;
        cnt_upd = 1'b0;
        if (load_i) begin
            cnt_nxt = load_val_i;
            cnt_upd = 1'b1;
        end else if (en_q && tick_i) begin
            cnt_nxt = cnt_q + CNT_W'(1);
            cnt_upd = 1'b1;
        end
    end

    // Purpose: register the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (en_wr_i) en_q <= en_val_i;
    end

    // Purpose: register the count.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

    assign en_o  = en_q;
    assign cnt_o = cnt_q;
    assign upd_o = cnt_upd;
    assign nxt_o = cnt_nxt;

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !(en_q && tick_i)) |=> $stable(cnt_q));
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && en_q && tick_i) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i)));
    p_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr_i |=> (en_q == $past(en_val_i)));

endmodule

// File: rtl/sec_rtc_irq.sv
// Alarm compare and interrupt status.
// Does: holds the alarm value and the mask bit, and latches the raw status
//       when the counter is updated onto the alarm value. A hit beats a clear.
// Assumes: upd_i/nxt_i describe the counter value taken at the coming edge.
module sec_rtc_irq #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alarm_wr_i,
    input  logic [CNT_W-1:0] alarm_val_i,
    input  logic             mask_wr_i,
    input  logic             mask_val_i,
    input  logic             ack_i,
    input  logic             upd_i,
    input  logic [CNT_W-1:0] nxt_i,
    output logic [CNT_W-1:0] alarm_o,
    output logic             mask_o,
    output logic             raw_o,
    output logic             masked_o
);

    logic [CNT_W-1:0] alarm_q;
    logic             mask_q;
    logic             raw_q;
    logic             hit;

    // Purpose: detect the counter landing on the alarm value.
    always_comb hit = upd_i && (nxt_i == alarm_q);

    // Purpose: register the alarm value.
    always_ff @(posedge clk) begin
        if (!rst_n)          alarm_q <= '0;
        else if (alarm_wr_i) alarm_q <= alarm_val_i;
    end

    // Purpose: register the mask bit.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= 1'b0;
        else if (mask_wr_i) mask_q <= mask_val_i;
    end

    // Purpose: sticky raw status, set by a hit and cleared by an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)     raw_q <= 1'b0;
        else if (hit)   raw_q <= 1'b1;
        else if (ack_i) raw_q <= 1'b0;
    end

    assign alarm_o  = alarm_q;
    assign mask_o   = mask_q;
    assign raw_o    = raw_q;
    assign masked_o = raw_q & mask_q;

    p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && (nxt_i == alarm_o)) |=> raw_o);
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_o && !ack_i) |=> raw_o);
    p_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_o) |-> $past(upd_i && (nxt_i == alarm_o)));
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !(upd_i && (nxt_i == alarm_o))) |=> !raw_o);

endmodule

// File: rtl/sec_rtc_regs.sv
// Register decode and read multiplexer.
// Does: turns a bus access into per-register write strobes and builds read data.
// Assumes: ADDR_W >= 6; only word-aligned addresses below 0x20 are decoded.
module sec_rtc_regs
    import sec_rtc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              valid_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CNT_W-1:0]  alarm_i,
    input  logic              en_i,
    input  logic              mask_i,
    input  logic              raw_i,
    input  logic              masked_i,
    output wr_strobe_t        strobe_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int SLOT_LSB = 2;
    localparam int SLOT_MSB = SLOT_LSB + $bits(slot_e) - 1;

    logic  in_window;
    slot_e slot;
    logic  rd_hit;
    logic  wr_hit;

    // Purpose: qualify the address and extract the word slot.
    always_comb begin
        in_window = (addr_i[SLOT_LSB-1:0] == '0) && (addr_i[ADDR_W-1:SLOT_MSB+1] == '0);
        slot      = slot_e'(addr_i[SLOT_MSB:SLOT_LSB]);
        rd_hit    = valid_i && !write_i && in_window;
        wr_hit    = valid_i &&  write_i && in_window;
    end

    // Purpose: raise one write strobe for the addressed writable register.
    always_comb begin
        strobe_o        = '0;
        strobe_o.alarm  = wr_hit && (slot == SLOT_ALARM);
        strobe_o.preset = wr_hit && (slot == SLOT_PRESET);
        strobe_o.ctrl   = wr_hit && (slot == SLOT_CTRL);
        strobe_o.mask   = wr_hit && (slot == SLOT_MASK);
        strobe_o.ack    = wr_hit && (slot == SLOT_ACK);
    end

    // Purpose: drive read data for a decoded read, zero otherwise.
    always_comb begin
        rdata_o = '0;
        if (rd_hit) begin
            unique case (slot)
                SLOT_COUNT:  rdata_o[CNT_W-1:0] = cnt_i;
                SLOT_ALARM:  rdata_o[CNT_W-1:0] = alarm_i;
                SLOT_CTRL:   rdata_o[0]         = en_i;
                SLOT_MASK:   rdata_o[0]         = mask_i;
                SLOT_RAW:    rdata_o[0]         = raw_i;
                SLOT_MASKED: rdata_o[0]         = masked_i;
                SLOT_PRESET,
                SLOT_ACK:    rdata_o            = '0;
            endcase
        end
    end

endmodule

// File: rtl/sec_rtc.sv
// Seconds real-time clock with alarm interrupt, top level.
// Does: wires the register decoder, the seconds counter and the alarm logic.
// Assumes: CNT_W <= DATA_W; tick_i synchronous to clk; reset synchronous active-low.
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    wr_strobe_t       strobe;
    logic             en;
    logic [CNT_W-1:0] cnt;
    logic             upd;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] alarm;
    logic             mask;
    logic             raw;
    logic             masked;

    sec_rtc_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .valid_i  (bus_valid_i),
        .write_i  (bus_write_i),
        .addr_i   (bus_addr_i),
        .cnt_i    (cnt),
        .alarm_i  (alarm),
        .en_i     (en),
        .mask_i   (mask),
        .raw_i    (raw),
        .masked_i (masked),
        .strobe_o (strobe),
        .rdata_o  (bus_rdata_o)
    );

    sec_rtc_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .en_wr_i    (strobe.ctrl),
        .en_val_i   (bus_wdata_i[0]),
        .load_i     (strobe.preset),
        .load_val_i (bus_wdata_i[CNT_W-1:0]),
        .en_o       (en),
        .cnt_o      (cnt),
        .upd_o      (upd),
        .nxt_o      (nxt)
    );

    sec_rtc_irq #(
        .CNT_W (CNT_W)
    ) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .alarm_wr_i  (strobe.alarm),
        .alarm_val_i (bus_wdata_i[CNT_W-1:0]),
        .mask_wr_i   (strobe.mask),
        .mask_val_i  (bus_wdata_i[0]),
        .ack_i       (strobe.ack && bus_wdata_i[0]),
        .upd_i       (upd),
        .nxt_i       (nxt),
        .alarm_o     (alarm),
        .mask_o      (mask),
        .raw_o       (raw),
        .masked_o    (masked)
    );

    assign irq_o = masked;

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid_i && !bus_write_i) |-> (bus_rdata_o == '0));
    p_onewrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe));
    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (raw && mask));

endmodule

// File: tb/sim_sec_rtc.sv
`timescale 1ns/1ps
module sim_sec_rtc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        valid = 1'b0;
    logic        write = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    // Behavioural reference state.
    logic [31:0] m_cnt = '0;
    logic [31:0] m_match = '0;
    logic        m_en = 1'b0;
    logic        m_mask = 1'b0;
    logic        m_raw = 1'b0;

    always #4 clk = ~clk;

    sec_rtc u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .bus_valid_i (valid),
        .bus_write_i (write),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00:   return m_cnt;
            8'h04:   return m_match;
            8'h0C:   return {31'd0, m_en};
            8'h10:   return {31'd0, m_mask};
            8'h14:   return {31'd0, m_raw};
            8'h18:   return {31'd0, m_raw & m_mask};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_for(input logic [7:0] a);
        case (a)
            8'h00:        return "R2";
            8'h04:        return "R5";
            8'h0C:        return "R3";
            8'h10, 8'h18: return "R7";
            8'h14:        return "R6";
            default:      return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, compare, then advance the model at the rising edge.
    task automatic step(input logic v, input logic w, input logic [7:0] a,
                        input logic [31:0] d, input logic t, input string tag = "");
        logic [31:0] nxt;
        logic        upd;
        @(negedge clk);
        valid = v; write = w; addr = a; wdata = d; tick = t;
        #1;
        if (v && !w) chk((tag != "") ? tag : tag_for(a), "rdata", rdata, model_read(a));
        else         chk("R10", "rdata idle", rdata, 32'd0);
        chk("R7", "irq", {31'd0, irq}, {31'd0, m_raw & m_mask});
        @(posedge clk);
        if (!rst_n) begin
            m_cnt = '0; m_match = '0; m_en = 1'b0; m_mask = 1'b0; m_raw = 1'b0;
        end else begin
            nxt = m_cnt;
            upd = 1'b0;
            if (v && w && a == 8'h08) begin nxt = d; upd = 1'b1; end
            else if (m_en && t) begin nxt = m_cnt + 32'd1; upd = 1'b1; end
            if (upd && nxt == m_match) m_raw = 1'b1;
            else if (v && w && a == 8'h1C && d[0]) m_raw = 1'b0;
            if (v && w && a == 8'h04) m_match = d;
            if (v && w && a == 8'h0C) m_en = d[0];
            if (v && w && a == 8'h10) m_mask = d[0];
            m_cnt = nxt;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic t = 1'b0);
        step(1'b1, 1'b1, a, d, t);
    endtask

    task automatic rd(input logic [7:0] a, input string tag = "");
        step(1'b1, 1'b0, a, 32'd0, 1'b0, tag);
    endtask

    task automatic idle(input logic t);
        step(1'b0, 1'b0, 8'h00, 32'hDEAD_BEEF, t);
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 8; i++) rd(8'(i * 4), tag);
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        lcg = 32'h1234_5678;
        // R1: reset state
        repeat (3) idle(1'b1);
        rst_n = 1'b1;
        read_all("R1");
        chk("R1", "irq after reset", {31'd0, irq}, 32'd0);

        // R5 / R2: alarm readback, preset
        wr(8'h04, 32'd5);
        rd(8'h04, "R5");
        wr(8'h08, 32'd3);
        rd(8'h00, "R2");

        // R3: no counting while disabled
        repeat (3) idle(1'b1);
        rd(8'h00, "R3");

        // R9: reserved control bits read zero
        wr(8'h0C, 32'hFF);
        rd(8'h0C, "R9");

        // R6 / R7: reach the alarm by ticking; masked until mask set
        idle(1'b1);
        idle(1'b1);
        rd(8'h00, "R3");
        rd(8'h14, "R6");
        rd(8'h18, "R7");
        wr(8'h10, 32'd1);
        rd(8'h18, "R7");

        // R8: zero acknowledge ignored, one clears
        wr(8'h1C, 32'hFFFF_FFFE);
        rd(8'h14, "R8");
        wr(8'h1C, 32'd1);
        rd(8'h14, "R8");

        // R8: hit and clear at the same edge, hit wins
        wr(8'h04, 32'd6);
        wr(8'h1C, 32'd1, 1'b1);
        rd(8'h14, "R8");
        rd(8'h00, "R2");
        wr(8'h1C, 32'd1);

        // R6: alarm written equal to the present count does not fire
        wr(8'h04, 32'd6);
        rd(8'h14, "R6");

        // R6: preset onto the alarm fires
        wr(8'h08, 32'd6);
        rd(8'h14, "R6");
        wr(8'h1C, 32'd1);

        // R2: preset beats tick
        wr(8'h08, 32'd100, 1'b1);
        rd(8'h00, "R2");

        // R3: disabled count holds under ticks
        wr(8'h0C, 32'd0);
        idle(1'b1);
        idle(1'b1);
        rd(8'h00, "R3");
        wr(8'h0C, 32'd1);

        // R4: wrap to zero, alarm at zero
        wr(8'h04, 32'd0);
        wr(8'h08, 32'hFFFF_FFFE);
        idle(1'b1);
        rd(8'h00, "R4");
        idle(1'b1);
        rd(8'h00, "R4");
        rd(8'h14, "R4");

        // R3: tick low holds
        idle(1'b0);
        idle(1'b0);
        rd(8'h00, "R3");

        // R9: ignored writes
        wr(8'h20, 32'h55);
        wr(8'h01, 32'h77);
        wr(8'h05, 32'h0);
        wr(8'h0D, 32'h0);
        wr(8'hFC, 32'h1);
        wr(8'h00, 32'h1234);
        wr(8'h14, 32'h0);
        wr(8'h18, 32'h0);
        read_all("R9");
        rd(8'h20, "R9");
        rd(8'h06, "R9");
        rd(8'h44, "R9");

        wr(8'h10, 32'd0);
        rd(8'h18, "R7");

        // Mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            logic [2:0]  slot;
            logic [31:0] dv;
            lcg  = lcg * 32'd1664525 + 32'd1013904223;
            slot = lcg[18:16];
            dv   = m_cnt + {29'd0, lcg[22:20]};
            if (lcg[23]) dv[0] = lcg[24];
            case (lcg[27:25])
                3'd0, 3'd1: idle(lcg[28]);
                3'd2, 3'd3: rd({3'd0, slot, 2'b00});
                default:    wr({3'd0, slot, 2'b00}, dv, lcg[28]);
            endcase
        end
        read_all("");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule